// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic down-counter meant to give software a regular time base. It holds a 24-bit count that falls by one on each selected tick. When a tick arrives while the count is already zero, the period ends and three things happen: the count is loaded again from the reload register, a sticky count flag is set, and, if the tick interrupt is enabled, a single-cycle pulse goes out to the interrupt controller. The tick is either every core clock cycle or a one-cycle enable strobe from an external reference.

Software reaches the block over a plain 32-bit register bus. Reads are combinational in the cycle of the access, and writes take effect at the next clock edge. There are four registers:

| Byte offset | Register | Access |
|---|---|---|
| 0x10 | control/status | read and write |
| 0x14 | reload value | read and write |
| 0x18 | current value | read; any write forces a reload |
| 0x1C | calibration | read only |

Disabling the timer keeps the remaining count so that it can be resumed later. A reload value of zero gives a one-shot: the timer switches itself off at the end of the period.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control bits, the count flag, the reload value and the count are all zero, `irq_pulse` is low, and every register reads zero except calibration.
- R2: The control/status register is at byte offset 0x10. Its bits are run = bit 0, tick interrupt enable = bit 1, clock-source select = bit 2 and count flag = bit 16. A write changes only bits 2..0. All other bits read zero.
- R3: A read of the control/status register returns the flag as it stands and then clears it. If a period ends in the same cycle as the read, the flag stays set.
- R4: When the run bit is written from 0 to 1 and the held count is zero, the count loads the reload value. Each tick then lowers the count by one, so a period lasts reload+1 ticks.
- R5: When a tick arrives while the count is zero, the period ends and the flag is set. `irq_pulse` is high for exactly one cycle, in the cycle after that tick, and only if bit 1 is set.
- R6: When a period ends and the reload value is zero, the run bit clears itself.
- R7: When a period ends and the reload value is not zero, the count reloads and counting continues with a period of reload+1 ticks.
- R8: A write of any data to offset 0x18 loads the count from the reload value and clears the flag.
- R9: Offset 0x18 reads zero while the run bit is 0. In the last tick interval of a period it also reads zero.
- R10: Writing the run bit from 1 to 0 freezes the count. Writing it back to 1 resumes from the frozen count when that count is not zero.
- R11: A control write that keeps the run bit at 1 but changes bit 2 reloads the count at once.
- R12: With bit 2 at 0, only cycles where `ref_tick` is high are ticks. With bit 2 at 1, every clock cycle is a tick.
- R13: Offset 0x1C reads the constant 10000, and writes to it are ignored. Offset 0x14 holds the low 24 bits of the written data. Any other offset reads zero.
- R14: A tick that falls in the same cycle as a write to offset 0x10 or 0x18 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick strobe, used when bit 2 of control is 0 |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, zero otherwise |
| irq_pulse | output | 1 | One-cycle interrupt request at the end of a period |

## Verification
The assertions check the per-cycle rules on every cycle:
- Each tick lowers the count by one.
- A count is frozen while the timer is stopped.
- A tick with the reference strobe low leaves the count unchanged.
- Reload, self-disable and flag clearing take effect after the right events.
- The interrupt pulse is one cycle wide.
- The fixed read fields hold their values.

Only the bench scenarios can show behaviour that spans many cycles: the full period lengths for both tick sources, resuming a frozen count after a pause, the reload forced by a source change, and the long mixed sequences of register traffic that the bench compares against its own model.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Register byte offsets; software depends on these values.
  localparam int OFS_CTRL    = 'h10;
  localparam int OFS_RELOAD  = 'h14;
  localparam int OFS_CURRENT = 'h18;
  localparam int OFS_CALIB   = 'h1C;

  // Control/status bit positions.
  localparam int BIT_RUN  = 0;
  localparam int BIT_IE   = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_CTRL,
    REG_RELOAD,
    REG_CURRENT,
    REG_CALIB
  } reg_sel_e;

  typedef struct packed {
    logic run;
    logic ie;
    logic src;
  } ctrl_t;

  // Build the control/status read word from its fields.
  function automatic logic [31:0] pack_ctrl(input ctrl_t c, input logic flag);
    logic [31:0] w;
    w = '0;
    w[BIT_RUN]  = c.run;
    w[BIT_IE]   = c.ie;
    w[BIT_SRC]  = c.src;
    w[BIT_FLAG] = flag;
    return w;
  endfunction

  // Unpack the writable control field from bus data.
  function automatic ctrl_t unpack_ctrl(input logic [2:0] d);
    ctrl_t c;
    c.run = d[BIT_RUN];
    c.ie  = d[BIT_IE];
    c.src = d[BIT_SRC];
    return c;
  endfunction

endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_ctrl,
  output logic              wr_reload,
  output logic              wr_cur,
  output logic              rd_ctrl,
  output logic              rd_reload,
  output logic              rd_cur,
  output logic              rd_calib
);

  reg_sel_e hit;

  always_comb begin
    hit = REG_NONE;
    if (bus_addr == ADDR_W'(OFS_CTRL))         hit = REG_CTRL;
    else if (bus_addr == ADDR_W'(OFS_RELOAD))  hit = REG_RELOAD;
    else if (bus_addr == ADDR_W'(OFS_CURRENT)) hit = REG_CURRENT;
    else if (bus_addr == ADDR_W'(OFS_CALIB))   hit = REG_CALIB;
  end

  logic is_wr, is_rd;
  assign is_wr = bus_sel & bus_wr;
  assign is_rd = bus_sel & ~bus_wr;

  // Writes to the calibration slot decode to nothing.
  assign wr_ctrl   = is_wr && (hit == REG_CTRL);
  assign wr_reload = is_wr && (hit == REG_RELOAD);
  assign wr_cur    = is_wr && (hit == REG_CURRENT);
  assign rd_ctrl   = is_rd && (hit == REG_CTRL);
  assign rd_reload = is_rd && (hit == REG_RELOAD);
  assign rd_cur    = is_rd && (hit == REG_CURRENT);
  assign rd_calib  = is_rd && (hit == REG_CALIB);

endmodule

// File: rtl/tt_tick_sel.sv
module tt_tick_sel (
  input  logic run,
  input  logic src_core,
  input  logic ref_tick,
  input  logic wr_ctrl,
  input  logic wr_cur,
  output logic tick_go
);

  logic raw_tick;
  logic bus_blocks;

  // Core clock gives a tick every cycle; otherwise follow the strobe.
  assign raw_tick   = src_core | ref_tick;
  // Register writes that touch the count take the cycle.
  assign bus_blocks = wr_ctrl | wr_cur;
  assign tick_go    = run & raw_tick & ~bus_blocks;

endmodule

// File: rtl/tt_counter_core.sv
module tt_counter_core
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_reload,
  input  logic             wr_cur,
  input  logic             rd_ctrl,
  input  logic [2:0]       ctrl_wdata,
  input  logic [CNT_W-1:0] reload_wdata,
  input  logic             tick_go,
  output ctrl_t            ctrl_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o,
  output logic             irq_o
);

  ctrl_t            ctrl_q;
  ctrl_t            ctrl_new;
  logic             flag_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;
  logic             irq_q;
  logic             expire;
  logic             count_zero;
  logic             reload_zero;

  assign ctrl_new    = unpack_ctrl(ctrl_wdata);
  assign count_zero  = (count_q == '0);
  assign reload_zero = (reload_q == '0);
  assign expire      = tick_go & count_zero;

  // Count after a tick: reload at the end of a period, else step down.
  function automatic logic [CNT_W-1:0] after_tick(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - CNT_W'(1);
  endfunction

  // Count after a control write: start, resume, or reload on source change.
  function automatic logic [CNT_W-1:0] after_ctrl(input ctrl_t old_c,
                                                  input ctrl_t new_c,
                                                  input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r);
    logic [CNT_W-1:0] n;
    n = c;
    if (!old_c.run && new_c.run)
      n = (c != '0) ? c : r;
    else if (old_c.run && new_c.run && (old_c.src != new_c.src))
      n = r;
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_new;
    end else if (expire && reload_zero) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_reload) begin
      reload_q <= reload_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr_ctrl) begin
      count_q <= after_ctrl(ctrl_q, ctrl_new, count_q, reload_q);
    end else if (wr_cur) begin
      count_q <= reload_q;
    end else if (tick_go) begin
      count_q <= after_tick(count_q, reload_q);
    end
  end

  // Set wins over the read-clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (wr_cur || rd_ctrl) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= expire & ctrl_q.ie;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign expire_o = expire;
  assign irq_o    = irq_q;

endmodule

// File: rtl/tt_read_mux.sv
module tt_read_mux
  import tick_timer_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input  logic             rd_ctrl,
  input  logic             rd_reload,
  input  logic             rd_cur,
  input  logic             rd_calib,
  input  ctrl_t            ctrl,
  input  logic             flag,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] reload,
  output logic [31:0]      rdata
);

  logic [31:0] cur_view;

  // A stopped timer shows zero in the current-value slot.
  assign cur_view = ctrl.run ? 32'(count) : 32'd0;

  always_comb begin
    rdata = 32'd0;
    unique case (1'b1)
      rd_ctrl:   rdata = pack_ctrl(ctrl, flag);
      rd_reload: rdata = 32'(reload);
      rd_cur:    rdata = cur_view;
      rd_calib:  rdata = 32'(CAL_VALUE);
      default:   rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pulse
);

  logic wr_ctrl, wr_reload, wr_cur;
  logic rd_ctrl, rd_reload, rd_cur, rd_calib;
  logic tick_go, expire;
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;

  tt_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wr_ctrl   (wr_ctrl),
    .wr_reload (wr_reload),
    .wr_cur    (wr_cur),
    .rd_ctrl   (rd_ctrl),
    .rd_reload (rd_reload),
    .rd_cur    (rd_cur),
    .rd_calib  (rd_calib)
  );

  tt_tick_sel u_tick (
    .run      (ctrl_q.run),
    .src_core (ctrl_q.src),
    .ref_tick (ref_tick),
    .wr_ctrl  (wr_ctrl),
    .wr_cur   (wr_cur),
    .tick_go  (tick_go)
  );

  tt_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .wr_reload    (wr_reload),
    .wr_cur       (wr_cur),
    .rd_ctrl      (rd_ctrl),
    .ctrl_wdata   (bus_wdata[2:0]),
    .reload_wdata (bus_wdata[CNT_W-1:0]),
    .tick_go      (tick_go),
    .ctrl_o       (ctrl_q),
    .flag_o       (flag_q),
    .count_o      (count_q),
    .reload_o     (reload_q),
    .expire_o     (expire),
    .irq_o        (irq_pulse)
  );

  tt_read_mux #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_rmux (
    .rd_ctrl   (rd_ctrl),
    .rd_reload (rd_reload),
    .rd_cur    (rd_cur),
    .rd_calib  (rd_calib),
    .ctrl      (ctrl_q),
    .flag      (flag_q),
    .count     (count_q),
    .reload    (reload_q),
    .rdata     (bus_rdata)
  );

  generate
    if (CNT_W < 32) begin : g_hi
      logic wdata_unused;
      assign wdata_unused = ^bus_wdata[31:CNT_W];
    end
  endgenerate

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W     = 24,
  parameter int CAL_VALUE = 10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic             run,
  input logic             ie,
  input logic             src,
  input logic             flag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             tick_go,
  input logic             expire,
  input logic             wr_ctrl,
  input logic             wr_cur,
  input logic             rd_ctrl,
  input logic             rd_cur,
  input logic             rd_calib,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             irq_pulse
);

  // R5
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (flag && ie));

  // R5
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  // R7
  reload_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload != '0) |=> (run && count == $past(reload)));

  // R6
  one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload == '0) |=> !run);

  // R8
  cur_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (count == $past(reload) && !flag));

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_ctrl && !wr_cur) |=> $stable(count));

  // R3
  flag_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !expire) |=> !flag);

  // R12
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src && !ref_tick && !wr_ctrl && !wr_cur) |=> $stable(count));

  // R14
  plain_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && run && wdata[0] && (wdata[2] == src)) |=> $stable(count));

  // R9
  stopped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cur && !run) |-> (rdata == 32'd0));

  // R13
  calib_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_calib |-> (rdata == 32'(CAL_VALUE)));

  // R2
  ctrl_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (rdata[15:3] == '0 && rdata[31:17] == '0));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_tick  (ref_tick),
  .run       (ctrl_q.run),
  .ie        (ctrl_q.ie),
  .src       (ctrl_q.src),
  .flag      (flag_q),
  .count     (count_q),
  .reload    (reload_q),
  .tick_go   (tick_go),
  .expire    (expire),
  .wr_ctrl   (wr_ctrl),
  .wr_cur    (wr_cur),
  .rd_ctrl   (rd_ctrl),
  .rd_cur    (rd_cur),
  .rd_calib  (rd_calib),
  .wdata     (bus_wdata),
  .rdata     (bus_rdata),
  .irq_pulse (irq_pulse)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;

  always #4 clk = ~clk;

  tick_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model state
  logic        m_run = 0, m_ie = 0, m_src = 0, m_flag = 0, m_irq = 0;
  logic [23:0] m_rel = 0, m_cnt = 0;
  logic        last_irq = 0;
  logic [31:0] last_rd = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_period(input int rel, input int gap);
    return (rel + 1) * gap;
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    case (a)
      8'h10:   return "R3";
      8'h14:   return "R13";
      8'h18:   return "R9";
      8'h1C:   return "R13";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h10:   return {15'b0, m_flag, 13'b0, m_src, m_ie, m_run};
      8'h14:   return {8'b0, m_rel};
      8'h18:   return m_run ? {8'b0, m_cnt} : 32'd0;
      8'h1C:   return 32'd10000;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_update(input logic s, input logic w, input logic [7:0] a,
                              input logic [31:0] d, input logic r);
    logic wctl, wrel, wcur, rctl, tick, ends;
    logic n_run, n_ie, n_src, n_flag;
    logic [23:0] n_cnt, n_rel;
    wctl = s && w && a == 8'h10;
    wrel = s && w && a == 8'h14;
    wcur = s && w && a == 8'h18;
    rctl = s && !w && a == 8'h10;
    tick = m_run && (m_src || r) && !wctl && !wcur;
    ends = tick && m_cnt == 0;
    n_run = m_run; n_ie = m_ie; n_src = m_src; n_cnt = m_cnt; n_rel = m_rel;
    n_flag = ends ? 1'b1 : ((wcur || rctl) ? 1'b0 : m_flag);
    if (wctl) begin
      n_run = d[0]; n_ie = d[1]; n_src = d[2];
      if (!m_run && d[0]) n_cnt = (m_cnt != 0) ? m_cnt : m_rel;
      else if (m_run && d[0] && d[2] != m_src) n_cnt = m_rel;
    end else if (wcur) begin
      n_cnt = m_rel;
    end else if (tick) begin
      if (m_cnt != 0) n_cnt = m_cnt - 1;
      else if (m_rel == 0) n_run = 1'b0;
      else n_cnt = m_rel;
    end
    if (wrel) n_rel = d[23:0];
    m_irq = ends && m_ie;
    m_run = n_run; m_ie = n_ie; m_src = n_src; m_flag = n_flag;
    m_cnt = n_cnt; m_rel = n_rel;
  endtask

  task automatic step(input logic s, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic r);
    @(negedge clk);
    last_irq = irq_pulse;
    chk(irq_pulse === m_irq, "R5", 32'(irq_pulse), 32'(m_irq));
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; ref_tick = r;
    #1;
    if (s && !w) begin
      last_rd = bus_rdata;
      chk(bus_rdata === model_read(a), tag_for(a), bus_rdata, model_read(a));
    end
    @(posedge clk);
    model_update(s, w, a, d, r);
  endtask

  task automatic idle(input logic r);
    step(1'b0, 1'b0, 8'h00, 32'h0, r);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    step(1'b1, 1'b0, a, 32'h0, 1'b0);
    chk(last_rd === exp, tag, last_rd, exp);
  endtask

  // Cycles between two successive interrupt pulses; ref toggles if alt set.
  task automatic measure(input bit alt, output int n);
    bit ph;
    int guard;
    ph = 1'b1;
    guard = 0;
    do begin idle(alt ? ph : 1'b0); ph = ~ph; guard++; end
    while (!last_irq && guard < 200);
    n = 0;
    do begin idle(alt ? ph : 1'b0); ph = ~ph; n++; end
    while (!last_irq && n < 200);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int per;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(8'h10, 32'h0, "R1");
    rd(8'h18, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    chk(irq_pulse === 1'b0, "R1", 32'(irq_pulse), 32'h0);

    // R4: start from zero count loads reload, then steps down
    wr(8'h14, 32'd3);
    wr(8'h10, 32'h5);
    idle(1'b0);
    rd(8'h18, 32'd2, "R4");
    // R11: source change with run held reloads
    wr(8'h10, 32'h1);
    rd(8'h18, 32'd3, "R11");
    // R12: only strobed cycles count
    idle(1'b0); idle(1'b0);
    rd(8'h18, 32'd3, "R12");
    repeat (4) idle(1'b1);
    // R2 and R3: flag at bit 16, read clears it
    rd(8'h10, 32'h0001_0001, "R2");
    rd(8'h10, 32'h0000_0001, "R3");
    // R5: interrupt only with bit 1
    wr(8'h10, 32'h3);
    repeat (4) idle(1'b1);
    idle(1'b0);
    chk(last_irq === 1'b1, "R5", 32'(last_irq), 32'h1);
    idle(1'b0);
    chk(last_irq === 1'b0, "R5", 32'(last_irq), 32'h0);
    // R10: freeze and resume
    idle(1'b1);
    wr(8'h10, 32'h2);
    rd(8'h18, 32'd0, "R9");
    repeat (3) idle(1'b1);
    wr(8'h10, 32'h3);
    rd(8'h18, 32'd2, "R10");
    // R8: any write to current reloads and clears flag
    idle(1'b1);
    wr(8'h18, 32'hDEAD_BEEF);
    rd(8'h18, 32'd3, "R8");
    rd(8'h10, 32'h3, "R8");
    // R6: zero reload stops after one period
    wr(8'h14, 32'd0);
    wr(8'h18, 32'd0);
    idle(1'b1);
    rd(8'h10, 32'h0001_0002, "R6");
    // R7: periodic with core clock
    wr(8'h14, 32'd3);
    wr(8'h10, 32'h7);
    measure(1'b0, per);
    chk(per == exp_period(3, 1), "R7", 32'(per), 32'(exp_period(3, 1)));
    // R12: reference strobe every other cycle
    wr(8'h10, 32'h3);
    measure(1'b1, per);
    chk(per == exp_period(3, 2), "R12", 32'(per), 32'(exp_period(3, 2)));
    // R13: calibration, unmapped, reload width
    wr(8'h1C, 32'd5);
    rd(8'h1C, 32'd10000, "R13");
    rd(8'h20, 32'd0, "R13");
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h00FF_FFFF, "R13");
    // R14: a tick during a control write is dropped
    wr(8'h10, 32'h5);
    wr(8'h14, 32'd5);
    wr(8'h18, 32'd0);
    rd(8'h18, 32'd5, "R14");
    wr(8'h10, 32'h5);
    rd(8'h18, 32'd4, "R14");
    wr(8'h10, 32'h0);

    // Constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        s, w;
      case ($urandom % 6)
        0: a = 8'h10;
        1: a = 8'h14;
        2: a = 8'h18;
        3: a = 8'h1C;
        4: a = 8'h10;
        default: a = 8'h24;
      endcase
      s = ($urandom % 4) == 0;
      w = ($urandom % 2) == 0;
      d = $urandom;
      if (a == 8'h14) d = (d & 32'hFF00_0000) | (d % 8);
      if (a == 8'h10 && ($urandom % 3) != 0) d[0] = 1'b1;
      step(s, w, a, d, 1'(($urandom % 2)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule